// File: doc/BRIEF.md
# Receive Block Aligner with Lock Detection

This block sits between a 32-bit serial-to-parallel receiver and a 64B/66B decoder. Every clock it accepts one 32-bit word whose bits are not yet aligned to block boundaries. It gathers those bits into 66-bit blocks: a 2-bit sync header followed by 64 payload bits. Each block leaves as two 32-bit halves on consecutive valid cycles, with the header presented alongside the first half. Input arrives at 32 bits per cycle and a block costs 66 bits, so the output valid strobe is low for one cycle in every 33.

A synchronization controller inspects the header of every block. While unlocked, it answers each invalid header with a one-cycle slip command. The slip makes the aligner discard a single bit, which moves the assumed block boundary one bit later. Once 64 valid headers arrive in a row, the controller declares lock. After lock it keeps counting invalid headers in windows of 64 blocks. Too many of them drop lock and restart the search.

A link indication is derived from lock together with an idle-block flag supplied by a downstream decoder. Link is raised only while locked and only after an idle block is flagged. It falls at the same moment as lock.

Top module: `rx_block_sync`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, valid_o, slip_o, lock_o and link_o are all low.
- R2: Received bits are taken LSB first. The first bit taken is block bit 0. hdr_o carries block bits [1:0] and is presented with the first half (first_o high), whose data_o is block bits [33:2]. The second half, block bits [65:34], follows on the next cycle with valid_o high and first_o low.
- R3: Once output has started and no slip occurs, valid_o is high in exactly 32 of every 33 cycles. It is never low on two consecutive cycles.
- R4: Each slip command discards exactly one received bit before the next block is formed. Starting k bits into an aligned stream therefore needs (66-k) mod 66 slips to reach lock.
- R5: A header is valid when its two bits differ (01 or 10). While unlocked, every invalid header (00 or 11) produces a slip_o pulse of exactly one cycle. The next header judged is taken from a block formed after that slip.
- R6: Lock rises on the cycle after the 64th consecutive valid header while unlocked.
- R7: While locked, invalid headers are counted in consecutive windows of 64 blocks. The 16th invalid header in one window drops lock. Fifteen invalid headers leave lock in place.
- R8: link_o rises on the cycle after a cycle in which lock_o and idle_i are both high. It then stays high while locked. idle_i has no effect while unlocked.
- R9: Loss of lock clears link_o on the same cycle. Slipping then resumes until lock is found again.
- R10: slip_o is never high while lock_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_word_i | input | 32 | Unaligned received bits, LSB first |
| idle_i | input | 1 | Decoder flags an idle block |
| data_o | output | 32 | Half-block payload |
| hdr_o | output | 2 | Sync header of the current block |
| first_o | output | 1 | data_o holds the first half of a block |
| valid_o | output | 1 | data_o holds a half-block this cycle |
| slip_o | output | 1 | One-cycle bit-slip command |
| lock_o | output | 1 | Block alignment found |
| link_o | output | 1 | Locked and idle seen |

## Verification
The following properties are checked by assertions on every cycle:
- There is never a double gap in valid.
- Halves always come in first-then-second pairs.
- A slip is a single-cycle pulse and never occurs while locked.
- Link is never high without lock.
- Lock and link rise only after a qualifying header or idle.

Other behaviour can only be shown by the bench's scenarios. The bench sweeps every one of the 66 starting bit offsets, and for each offset it checks:
- the exact slip count needed to reach lock;
- the bit ordering of recovered payloads.

Further scenarios cover:
- the exact 32-of-33 valid rate;
- idle being ignored before lock;
- the 15-versus-16 invalid-header boundary;
- relock after loss.

// File: rtl/rbs_pkg.sv
`timescale 1ns/1ps
package rbs_pkg;
  localparam int unsigned HDR_W = 2;

  function automatic logic hdr_good(input logic [HDR_W-1:0] h);
    return h[0] ^ h[1];
  endfunction
endpackage

// File: rtl/rbs_gearbox.sv
`timescale 1ns/1ps
module rbs_gearbox #(
  parameter int unsigned W  = 32,
  parameter int unsigned HW = rbs_pkg::HDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  word_i,
  input  logic          slip_i,
  output logic [W-1:0]  data_o,
  output logic [HW-1:0] hdr_o,
  output logic          first_o,
  output logic          valid_o
);
  localparam int unsigned BUFW = W + HW + 1;
  localparam int unsigned EXTW = BUFW + W;
  localparam int unsigned CW   = $clog2(EXTW + 1);

  logic [BUFW-1:0] buf_q;
  logic [CW-1:0]   cnt_q;
  logic            half_q, pend_q, run_q;
  logic [EXTW-1:0] ext, sh;
  logic [CW-1:0]   avail, need;
  logic            drop, emit;

  always_comb begin
    ext   = EXTW'(buf_q) | (EXTW'(word_i) << cnt_q);
    avail = cnt_q + CW'(W);
    drop  = !half_q && (slip_i || pend_q);
    need  = half_q ? CW'(W) : CW'(W + HW) + CW'(drop);
    emit  = avail >= need;
    sh    = ext >> drop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
      data_o  <= '0;
      hdr_o   <= '0;
      first_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= emit;
      first_o <= emit && !half_q;
      run_q   <= run_q | emit;
      if (emit) begin
        buf_q  <= BUFW'(ext >> need);
        cnt_q  <= avail - need;
        half_q <= !half_q;
        pend_q <= half_q ? (pend_q | slip_i) : 1'b0;
        if (!half_q) begin
          hdr_o  <= sh[HW-1:0];
          data_o <= sh[HW+W-1:HW];
        end else begin
          data_o <= ext[W-1:0];
        end
      end else begin
        buf_q  <= BUFW'(ext);
        cnt_q  <= avail;
        pend_q <= pend_q | slip_i;
      end
    end
  end

  // R3
  valid_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !valid_o |=> valid_o);

  // R2
  half_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && first_o |=> valid_o && !first_o);
endmodule

// File: rtl/rbs_sync.sv
`timescale 1ns/1ps
module rbs_sync #(
  parameter int unsigned LOCK_CNT = 64,
  parameter int unsigned WIN_LEN  = 64,
  parameter int unsigned BAD_MAX  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hdr_vld_i,
  input  logic [1:0] hdr_i,
  input  logic       idle_i,
  output logic       slip_o,
  output logic       lock_o,
  output logic       link_o
);
  localparam int unsigned GW = $clog2(LOCK_CNT + 1);
  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  localparam int unsigned BW = $clog2(BAD_MAX + 1);

  logic [GW-1:0] good_q;
  logic [WW-1:0] win_q;
  logic [BW-1:0] bad_q;
  logic          ok, lose;

  assign ok   = rbs_pkg::hdr_good(hdr_i);
  assign lose = hdr_vld_i && lock_o && !ok && (bad_q == BW'(BAD_MAX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      win_q  <= '0;
      bad_q  <= '0;
      slip_o <= 1'b0;
      lock_o <= 1'b0;
      link_o <= 1'b0;
    end else begin
      slip_o <= 1'b0;
      link_o <= lose ? 1'b0 : (link_o | (lock_o & idle_i));
      if (hdr_vld_i) begin
        if (!lock_o) begin
          if (ok) begin
            if (good_q == GW'(LOCK_CNT - 1)) begin
              lock_o <= 1'b1;
              good_q <= '0;
              win_q  <= '0;
              bad_q  <= '0;
            end else begin
              good_q <= good_q + 1'b1;
            end
          end else begin
            slip_o <= 1'b1;
            good_q <= '0;
          end
        end else if (lose) begin
          lock_o <= 1'b0;
          good_q <= '0;
          win_q  <= '0;
          bad_q  <= '0;
        end else if (win_q == WW'(WIN_LEN - 1)) begin
          win_q <= '0;
          bad_q <= '0;
        end else begin
          win_q <= win_q + 1'b1;
          bad_q <= bad_q + BW'(!ok);
        end
      end
    end
  end

  // R10
  slip_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> !lock_o);

  // R5
  slip_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o);

  // R6
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(hdr_vld_i && ok));

  // R9
  link_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |-> lock_o);

  // R8
  link_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_o) |-> $past(idle_i && lock_o));
endmodule

// File: rtl/rx_block_sync.sv
`timescale 1ns/1ps
module rx_block_sync #(
  parameter int unsigned W        = 32,
  parameter int unsigned LOCK_CNT = 64,
  parameter int unsigned WIN_LEN  = 64,
  parameter int unsigned BAD_MAX  = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rx_word_i,
  input  logic         idle_i,
  output logic [W-1:0] data_o,
  output logic [1:0]   hdr_o,
  output logic         first_o,
  output logic         valid_o,
  output logic         slip_o,
  output logic         lock_o,
  output logic         link_o
);
  logic hdr_vld;

  rbs_gearbox #(.W(W), .HW(rbs_pkg::HDR_W)) u_gearbox (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .word_i  (rx_word_i),
    .slip_i  (slip_o),
    .data_o  (data_o),
    .hdr_o   (hdr_o),
    .first_o (first_o),
    .valid_o (valid_o)
  );

  assign hdr_vld = valid_o & first_o;

  rbs_sync #(.LOCK_CNT(LOCK_CNT), .WIN_LEN(WIN_LEN), .BAD_MAX(BAD_MAX)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hdr_vld_i (hdr_vld),
    .hdr_i     (hdr_o),
    .idle_i    (idle_i),
    .slip_o    (slip_o),
    .lock_o    (lock_o),
    .link_o    (link_o)
  );
endmodule

// File: tb/rx_block_sync_bench.sv
`timescale 1ns/1ps
module rx_block_sync_bench;
  localparam logic [31:0] KX = 32'hA5C3_5A3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word = '0;
  logic        idle = 1'b0;
  logic [31:0] data_o;
  logic [1:0]  hdr_o;
  logic        first_o, valid_o, slip_o, lock_o, link_o;

  int     total = 0, bad = 0, slips = 0, errs = 0;
  longint pos = 0, bad_lo = -1, bad_hi = -1;
  bit     chk_en = 0, exp2 = 0;
  logic [31:0] f1;

  rx_block_sync u_rx_block_sync (
    .clk_i(clk), .rst_ni(rst_n), .rx_word_i(word), .idle_i(idle),
    .data_o(data_o), .hdr_o(hdr_o), .first_o(first_o), .valid_o(valid_o),
    .slip_o(slip_o), .lock_o(lock_o), .link_o(link_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] hashj(input longint j);
    return (32'(j) * 32'h9E37_79B1) ^ 32'h5BD1_E995;
  endfunction

  function automatic logic gbit(input longint n);
    longint j = n / 66;
    int p = int'(n % 66);
    logic [31:0] h = hashj(j);
    logic [31:0] h2 = h ^ KX;
    logic [1:0] hd = h[0] ? 2'b10 : 2'b01;
    if (j >= bad_lo && j <= bad_hi) hd = 2'b00;
    if (p < 2) return hd[p];
    if (p < 34) return h[p-2];
    return h2[p-34];
  endfunction

  function automatic logic [31:0] gword(input longint n);
    logic [31:0] w;
    for (int b = 0; b < 32; b++) w[b] = gbit(n + b);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (slip_o) slips++;
    if (chk_en && valid_o) begin
      if (first_o) begin
        if (hdr_o != (data_o[0] ? 2'b10 : 2'b01)) errs++;
        f1 = data_o; exp2 = 1;
      end else if (exp2) begin
        if (data_o != (f1 ^ KX)) errs++;
        exp2 = 0;
      end
    end
    word = gword(pos);
    pos += 32;
  endtask

  task automatic do_reset(input int k);
    rst_n = 1'b0; bad_lo = -1; bad_hi = -1; chk_en = 0;
    repeat (3) @(negedge clk);
    pos = k; word = gword(pos); pos += 32;
    rst_n = 1'b1; slips = 0;
  endtask

  task automatic wait_lock(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      tick();
      if (lock_o) begin got = 1; break; end
    end
  endtask

  task automatic align_check(input string req);
    errs = 0; exp2 = 0; chk_en = 1;
    repeat (40) tick();
    chk_en = 0;
    chk(errs == 0, req, errs, 0);
  endtask

  task automatic run_offset(input int k);
    bit got;
    int exp_s = (66 - k) % 66;
    do_reset(k); idle = 1'b1;
    wait_lock(3000, got);
    chk(got, "R6 lock reached", got, 1);
    chk(slips == exp_s, "R4 slip count", slips, exp_s);
    chk(link_o == 1'b0, "R8 link after lock", link_o, 0);
    tick();
    chk(link_o == 1'b1, "R8 link rise", link_o, 1);
    align_check("R2 alignment");
  endtask

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit got, held, prevz, dbl;
    int vc, fc;
    // R1 reset state
    do_reset(0); idle = 1'b0;
    chk(valid_o == 0 && lock_o == 0 && link_o == 0 && slip_o == 0, "R1 in reset", {valid_o, lock_o, link_o, slip_o}, 0);
    tick();
    chk(valid_o == 0 && lock_o == 0 && link_o == 0 && slip_o == 0, "R1 first cycle", {valid_o, lock_o, link_o, slip_o}, 0);
    wait_lock(3000, got);
    chk(got, "R6 lock offset 0", got, 1);
    chk(slips == 0, "R4 no slips at offset 0", slips, 0);
    // R3 valid rate
    vc = 0; fc = 0; prevz = 0; dbl = 0;
    for (int i = 0; i < 330; i++) begin
      tick();
      if (valid_o) vc++;
      if (valid_o && first_o) fc++;
      if (!valid_o && prevz) dbl = 1;
      prevz = !valid_o;
    end
    chk(vc == 320, "R3 valid count", vc, 320);
    chk(fc == 160, "R3 block count", fc, 160);
    chk(!dbl, "R3 no double gap", dbl, 0);
    // R8 idle needed, sticky
    chk(link_o == 0, "R8 no idle no link", link_o, 0);
    idle = 1'b1; tick(); idle = 1'b0;
    chk(link_o == 1, "R8 idle sets link", link_o, 1);
    repeat (20) tick();
    chk(link_o == 1, "R8 link sticky", link_o, 1);
    // R8 idle ignored before lock
    do_reset(3); idle = 1'b1;
    repeat (30) tick();
    chk(link_o == 0 && lock_o == 0, "R8 idle while unlocked", link_o, 0);
    // offset sweep
    for (int k = 0; k < 66; k++) run_offset(k);
    // R7 / R9 loss of lock
    do_reset(7); idle = 1'b1;
    wait_lock(3000, got);
    tick();
    chk(link_o == 1, "R8 link before loss", link_o, 1);
    bad_lo = pos / 66 + 10; bad_hi = bad_lo + 14;
    held = 1;
    repeat (200) begin tick(); if (!lock_o) held = 0; end
    chk(held, "R7 fifteen bad keep lock", held, 1);
    bad_lo = pos / 66 + 10; bad_hi = bad_lo + 31;
    got = 0;
    for (int i = 0; i < 400; i++) begin
      tick();
      if (!lock_o) begin got = 1; break; end
    end
    chk(got, "R7 lock dropped", got, 1);
    chk(link_o == 0, "R9 link cleared with lock", link_o, 0);
    slips = 0;
    wait_lock(4000, got);
    chk(got, "R9 relock", got, 1);
    chk(slips > 0 && slips % 66 == 0, "R5 slips resumed", slips, 66);
    align_check("R9 alignment after relock");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule